// File: doc/BRIEF.md
# Asynchronous PSRAM Write Cycle Generator

This block sits between a host on a synchronous system clock and a pseudo-static RAM whose write port has no clock. Each request the host hands over carries an address, a 16-bit word and two byte-enable bits. The block turns that request into one asynchronous write. The chip select, write enable and the selected byte strobes are pulled low together, held for a whole number of clock cycles, and released together. After that the block waits out the rest of the memory's cycle time before it takes the next request. Every nanosecond minimum becomes a cycle count, computed as the ceiling of the minimum divided by the clock period.

The host port uses valid/ready. A request moves across on a clock edge where `req_valid` and `req_ready` are both high. The host must then hold its request stable while `req_valid` is high and `req_ready` is low. `req_ready` drops on the edge that accepts a request and stays low until the cycle-time count has run out. That low period is the only back-pressure the block applies.

The block counts runs of continuous writes. A run is broken when the port sits ready with no request for at least one full cycle time. Once a run has gone past the run limit (50 by default), every later write in the run uses a longer write pulse and a longer cycle. The run counter saturates instead of wrapping.

Top module: `psram_async_writer`

## Requirements
- R1: Out of reset, chip select, write enable and both byte strobes are high (inactive), the data driver enable is low and `req_ready` is high.
- R2: In the cycle after a request is accepted, `mem_cs_n` and `mem_we_n` are low, `mem_addr` and `mem_dq` carry the request, `mem_ub_n` is low exactly when `req_be[1]` is 1 and `mem_lb_n` is low exactly when `req_be[0]` is 1.
- R3: A request with `req_be` = 2'b00 still runs a cycle, but neither byte strobe goes low, so the memory stores nothing.
- R4: Chip select, write enable and the active byte strobes stay low together for the window length and rise on the same edge. The address and data stay stable through the window. At the default parameters the normal window is 6 cycles: the largest of ceil(60/10), ceil(55/10) and ceil(30/10).
- R5: `mem_dq_oe` is high from the first cycle of the window through the cycle after the window ends. It is low in the next cycle unless a new window has begun.
- R6: `req_ready` is low from the accepting edge until the cycle-time count completes. With requests held back to back, window starts are spaced by max(ceil(70/10), window+1) cycles: 7 cycles normally.
- R7: In a run of continuous writes, the writes after the 50th use a 7-cycle window (ceil(70/10)) and a start-to-start spacing of 8 cycles.
- R8: The run is cleared only when the port has spent at least 7 cycles (the cycle time) ready with no request since the previous acceptance. A gap of 6 such cycles keeps the long window. A gap of exactly 7 cycles, followed directly by a request, gives a normal window.
- R9: `mem_oe_n` and `mem_cfg_sel_n` stay high at all times.
- R10: The run count saturates at the run limit, so writes 51 to 60 of a run all keep the long window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | 16 | Write data word |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_oe_n | output | 1 | Output enable, held high |
| mem_cfg_sel_n | output | 1 | Configuration-register select, held high |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | output | 16 | Memory data bus value |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
Two things can land on the same clock edge: the expiry of the idle gap that clears a run, and the acceptance of the next request. In that case the new request must already see the cleared run. The bench provokes this by running 60 writes back to back, so the run saturates. It then holds the port ready and idle for exactly 6 cycles before the next request, and later for exactly 7 cycles. The scoreboard, which keeps its own model of the run and the gap, expects a long 7-cycle window after the 6-cycle gap and a normal 6-cycle window after the 7-cycle gap. The monitor measures the window length at the memory pins.

// File: rtl/psram_wr_pkg.sv
package psram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_RECOVER = 2'd2
  } wr_state_e;

  // Whole clock cycles needed to cover a minimum time in ns.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_run_tracker.sv
module psram_run_tracker #(
  parameter int RUN_LEN = 50,
  parameter int GAP_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic idle_tick,
  output logic long_sel
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [RW-1:0] run_cnt;
  logic [GW-1:0] gap_cnt;
  logic [RW-1:0] prev_run;

  // A long enough idle gap clears the run in the same cycle that a request lands.
  assign prev_run = (gap_cnt >= GW'(GAP_CYC)) ? '0 : run_cnt;
  assign long_sel = (prev_run >= RW'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      gap_cnt <= GW'(GAP_CYC);
    end else if (accept) begin
      gap_cnt <= '0;
      run_cnt <= long_sel ? RW'(RUN_LEN) : prev_run + 1'b1;
    end else if (idle_tick && (gap_cnt < GW'(GAP_CYC))) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  AST_RUN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RW'(RUN_LEN)); // R10

  AST_LONG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && long_sel) |=> (run_cnt == RW'(RUN_LEN))); // R7

endmodule

// File: rtl/psram_wr_seq.sv
module psram_wr_seq
  import psram_wr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] win_len,
  input  logic [CNT_W-1:0] period,
  output logic             ready,
  output logic             cs_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             finish
);
  wr_state_e        state;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] per_q;

  assign finish = (state == ST_WRITE) && (elapsed == win_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      elapsed <= '0;
      win_q   <= '0;
      per_q   <= '0;
      cs_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_WRITE;
            elapsed <= CNT_W'(1);
            win_q   <= win_len;
            per_q   <= period;
            cs_n    <= 1'b0;
            we_n    <= 1'b0;
            dq_oe   <= 1'b1;
            ready   <= 1'b0;
          end else begin
            dq_oe   <= 1'b0;
          end
        end
        ST_WRITE: begin
          elapsed <= elapsed + 1'b1;
          if (finish) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
            if (elapsed + 1'b1 == per_q) begin
              state <= ST_IDLE;
              ready <= 1'b1;
            end else begin
              state <= ST_RECOVER;
            end
          end
        end
        ST_RECOVER: begin
          dq_oe   <= 1'b0;
          elapsed <= elapsed + 1'b1;
          if (elapsed + 1'b1 == per_q) begin
            state <= ST_IDLE;
            ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready); // R6

  AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe); // R5

  AST_HOLD_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe); // R5

  AST_PAIR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $rose(we_n)); // R4

endmodule

// File: rtl/psram_wr_lanes.sv
module psram_wr_lanes #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    finish,
  input  logic                    cs_n,
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [LANES*LANE_W-1:0] in_data,
  input  logic [LANES-1:0]        in_be,
  output logic [ADDR_W-1:0]       addr,
  output logic [LANES*LANE_W-1:0] dq,
  output logic [LANES-1:0]        lane_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      dq   <= '0;
    end else if (accept) begin
      addr <= in_addr;
      dq   <= in_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_n[g] <= 1'b1;
      else if (accept) lane_n[g] <= ~in_be[g];
      else if (finish) lane_n[g] <= 1'b1;
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(addr) && $stable(dq))); // R4

  AST_LANES_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (&lane_n)); // R3

endmodule

// File: rtl/psram_async_writer.sv
module psram_async_writer
  import psram_wr_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CLK_NS      = 10,
  parameter int T_WC_NS     = 70,
  parameter int T_CW_NS     = 60,
  parameter int T_AW_NS     = 60,
  parameter int T_BW_NS     = 60,
  parameter int T_WP_NS     = 55,
  parameter int T_WP_RUN_NS = 70,
  parameter int T_DW_NS     = 30,
  parameter int RUN_LEN     = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  input  logic [1:0]        req_be,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic              mem_oe_n,
  output logic              mem_cfg_sel_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq,
  output logic              mem_dq_oe
);
  localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int SETUP_CYC = max2(max2(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                  max2(ns_to_cyc(T_BW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int WIN_SHORT = max2(SETUP_CYC, ns_to_cyc(T_WP_NS, CLK_NS));
  localparam int WIN_LONG  = max2(WIN_SHORT, ns_to_cyc(T_WP_RUN_NS, CLK_NS));
  localparam int PER_SHORT = max2(WC_CYC, WIN_SHORT + 1);
  localparam int PER_LONG  = max2(WC_CYC, WIN_LONG + 1);
  localparam int CNT_W     = $clog2(PER_LONG + 1);

  logic             accept;
  logic             idle_tick;
  logic             long_sel;
  logic             finish;
  logic [CNT_W-1:0] win_len;
  logic [CNT_W-1:0] period;
  logic [1:0]       lane_n;

  assign accept    = req_valid && req_ready;
  assign idle_tick = req_ready && !req_valid;
  assign win_len   = long_sel ? CNT_W'(WIN_LONG) : CNT_W'(WIN_SHORT);
  assign period    = long_sel ? CNT_W'(PER_LONG) : CNT_W'(PER_SHORT);

  psram_run_tracker #(.RUN_LEN(RUN_LEN), .GAP_CYC(WC_CYC)) u_run (
    .clk(clk), .rst_n(rst_n), .accept(accept), .idle_tick(idle_tick), .long_sel(long_sel)
  );

  psram_wr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .win_len(win_len), .period(period),
    .ready(req_ready), .cs_n(mem_cs_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe), .finish(finish)
  );

  psram_wr_lanes #(.ADDR_W(ADDR_W), .LANES(2), .LANE_W(8)) u_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish), .cs_n(mem_cs_n),
    .in_addr(req_addr), .in_data(req_data), .in_be(req_be),
    .addr(mem_addr), .dq(mem_dq), .lane_n(lane_n)
  );

  assign mem_ub_n      = lane_n[1];
  assign mem_lb_n      = lane_n[0];
  assign mem_oe_n      = 1'b1;
  assign mem_cfg_sel_n = 1'b1;

  AST_WIN_HAS_LANES_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_ub_n && mem_lb_n)); // R4

endmodule

// File: tb/sim_psram_async_writer.sv
module sim_psram_async_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_be = '0;
  logic        mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n, mem_oe_n, mem_cfg_sel_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq;
  logic        mem_dq_oe;

  always #5 clk = ~clk;

  psram_async_writer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_oe_n(mem_oe_n), .mem_cfg_sel_n(mem_cfg_sel_n), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  typedef struct packed {
    logic [19:0] addr;
    logic [15:0] data;
    logic        ub_n;
    logic        lb_n;
    logic [3:0]  win;
    logic [3:0]  gap;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   run_m  = 0;
  int   gap_m  = 7;
  int   last_per = 7;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Driver: presents one request and pushes its expected memory cycle.
  task automatic send(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be, input bit b2b);
    int   w;
    int   prev;
    bit   lng;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_be = be;
    w = 0;
    while (!req_ready) begin
      @(negedge clk);
      w++;
      if (w > 100) begin
        chk(1'b0, "R6 ready never returned", 0, 1);
        return;
      end
    end
    prev  = (gap_m >= 7) ? 0 : run_m;
    lng   = (prev >= 50);
    run_m = lng ? 50 : prev + 1;
    gap_m = 0;
    e.addr = a; e.data = d;
    e.ub_n = ~be[1]; e.lb_n = ~be[0];
    e.win  = lng ? 4'd7 : 4'd6;
    e.gap  = b2b ? 4'(last_per) : 4'd0;
    last_per = lng ? 8 : 7;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R6 ready low after accept", int'(req_ready), 0);
  endtask

  // Holds the port idle for n cycles in which the block is ready.
  task automatic idle_ready(input int n);
    int c;
    @(negedge clk);
    req_valid = 1'b0;
    c = 0;
    forever begin
      if (req_ready) begin
        c++;
        gap_m++;
      end
      if (c >= n) break;
      @(negedge clk);
    end
  endtask

  // Monitor: pops expected cycles as windows appear on the memory pins.
  int   cyc = 0;
  int   last_start = 0;
  int   len = 0;
  bit   prev_we = 1'b1;
  bit   after_hold = 1'b0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!mem_oe_n || !mem_cfg_sel_n) chk(1'b0, "R9 oe/cfg select high", int'({mem_oe_n, mem_cfg_sel_n}), 3);
      if (after_hold && mem_we_n) chk(!mem_dq_oe, "R5 driver released", int'(mem_dq_oe), 0);
      after_hold = 1'b0;
      if (!mem_we_n && prev_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write", 1, 0);
          cur = '0;
        end else begin
          cur = exp_q.pop_front();
          chk(mem_addr == cur.addr, "R2 address", int'(mem_addr), int'(cur.addr));
          chk(mem_dq == cur.data, "R2 data", int'(mem_dq), int'(cur.data));
          chk(!mem_cs_n && mem_dq_oe, "R2 cs low and driving", int'({mem_cs_n, mem_dq_oe}), 1);
          chk(mem_ub_n == cur.ub_n && mem_lb_n == cur.lb_n, "R2 R3 byte strobes",
              int'({mem_ub_n, mem_lb_n}), int'({cur.ub_n, cur.lb_n}));
          if (cur.gap != 0) chk(cyc - last_start == int'(cur.gap), "R6 R7 start spacing",
                                cyc - last_start, int'(cur.gap));
        end
        last_start = cyc;
        len = 1;
      end else if (!mem_we_n) begin
        len++;
        if (mem_cs_n || mem_addr != cur.addr || mem_dq != cur.data || !mem_dq_oe ||
            mem_ub_n != cur.ub_n || mem_lb_n != cur.lb_n)
          chk(1'b0, "R4 window stable", 0, 1);
      end else if (!prev_we) begin
        chk(len == int'(cur.win), "R4 R7 R8 window length", len, int'(cur.win));
        chk(mem_cs_n && mem_ub_n && mem_lb_n, "R4 joint release", int'({mem_cs_n, mem_ub_n, mem_lb_n}), 7);
        chk(mem_dq_oe, "R5 data hold cycle", int'(mem_dq_oe), 1);
        after_hold = 1'b1;
      end
      prev_we = mem_we_n;
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes idle",
        int'({mem_cs_n, mem_we_n, mem_ub_n, mem_lb_n}), 15);
    chk(!mem_dq_oe, "R1 driver off", int'(mem_dq_oe), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);
    chk(mem_oe_n && mem_cfg_sel_n, "R9 idle pins", int'({mem_oe_n, mem_cfg_sel_n}), 3);
    rst_n = 1'b1;

    // R2 and R3 byte-enable patterns
    send(20'h12345, 16'hA55A, 2'b11, 1'b0);
    idle_ready(3);
    send(20'h00F0F, 16'h1234, 2'b10, 1'b0);
    idle_ready(2);
    send(20'hFFFFF, 16'hBEEF, 2'b01, 1'b0);
    idle_ready(1);
    send(20'h0ABCD, 16'h0F0F, 2'b00, 1'b0);
    idle_ready(8);

    // R6 R7 R10: a 60-write continuous run
    for (int i = 0; i < 60; i++)
      send(20'(i * 7 + 3), 16'(i * 16'h0101 + 16'h0042), 2'(i % 3 + 1), (i != 0));

    // R8: a 6-cycle gap keeps the long window, a 7-cycle gap clears it
    idle_ready(6);
    send(20'h3C3C3, 16'hC0DE, 2'b11, 1'b0);
    idle_ready(7);
    send(20'h5A5A5, 16'hD00D, 2'b11, 1'b0);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule